// File: doc/BRIEF.md
# OTP Memory Program-Verify Sequencer

This controller writes a full image into an external byte-wide one-time-programmable memory. An erased part reads as all ones, and programming can only clear bits. After a start request the controller walks the array from the lowest address to the highest. It fetches each target byte from a data source port that answers combinationally for the address it is given. For every byte that needs programming, it applies a timed program pulse with the high-voltage request raised and chip enable low. It then drops the high-voltage request, lowers chip enable again and samples the memory a fixed number of cycles later. If the byte read back does not match the target, it issues another pulse. This repeats until the byte matches or a per-address pulse cap is reached.

The whole programming phase runs with the supply-level select driving the elevated rail. Once the last address is done, the controller switches the select back to the nominal rail. It then reads the whole array a second time and compares every byte against the source. A byte that reaches its pulse cap, or any mismatch in the final pass, stops the run. In that case the controller raises an error and reports the failing address. A clean run raises done. Either flag holds until the next start.

The chip enable output is a single device select. When several memories share the address, data and high-voltage lines, each device gets its own sequencer's chip enable. A device whose enable stays high is not programmed.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is held and after its release, chip enable is high, the high-voltage request is low, the supply select is at nominal (0), and done and error are both 0.
- R2: Every program pulse holds chip enable low and the high-voltage request high for exactly PULSE_CYC consecutive cycles. During the pulse, the write-data bus carries the source byte of the current address.
- R3: After each pulse there is at least one cycle with chip enable high and the high-voltage request low. A verify read then holds chip enable low with the high-voltage request low, and the read data is sampled at the end of the VFY_DLY-th cycle after chip enable fell. The high-voltage request only rises after a cycle with chip enable high.
- R4: When a verify read mismatches and fewer than MAX_PULSES pulses have been applied to the address, another pulse is applied. An address that needs k pulses (k ≤ MAX_PULSES) receives exactly k.
- R5: When MAX_PULSES pulses have been applied to one address and the last verify still mismatches, the run stops with error=1, done=0, and the failing address on the fail-address output. No later address is pulsed and no final pass is run.
- R6: An address whose source byte is 0xFF receives no program pulse.
- R7: Addresses are visited in ascending order, from 0 to 2^ADDR_W−1, in both phases. The address outputs change only while chip enable is high.
- R8: The supply select is 1 for the whole programming phase and for every program pulse. It is 0 for the whole final read pass. The high-voltage request is never high while the supply select is 0.
- R9: The final pass reads every address exactly once, each with its own chip enable fall. A mismatch stops the run with error=1 and that address on the fail-address output.
- R10: A clean run ends with done=1 and error=0. Done and error are never both 1. After the run ends, chip enable stays high and the high-voltage request stays low. A start pulse while a run is in progress has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a run (accepted when not busy) |
| done_o | output | 1 | Run finished cleanly, held until next start |
| err_o | output | 1 | Run stopped on a failure, held until next start |
| fail_addr_o | output | ADDR_W | Address at which the run failed |
| src_addr_o | output | ADDR_W | Address presented to the data source |
| src_data_i | input | DATA_W | Target byte for src_addr_o |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Program data, 0xFF outside pulses |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_ce_n_o | output | 1 | Active-low chip enable |
| mem_hv_o | output | 1 | Program high-voltage request |
| supply_hi_o | output | 1 | Supply select: 1 elevated, 0 nominal |

## Verification
The assertions assume that the data source answers for the address currently presented and stays stable while that address is held. They also assume that start is only a request and the block ignores it while busy. Given these, the assertions check pulse width, enable/high-voltage ordering and address stability against the block's own outputs alone. The bench keeps its source image fixed for a whole run and answers the address combinationally. Its memory model returns corrupted data when sampled before the verify delay has passed, so a read taken too early shows up as a failed run. The model programs a byte only after a given number of full-width pulses, and it can disturb a byte when the supply drops, which drives the retry, cap and final-pass failure paths.

// File: rtl/otp_seq_pkg.sv
// Shared types for the OTP program-verify sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package otp_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PULSE,
        ST_PGAP,
        ST_VERIFY,
        ST_VGAP,
        ST_NEXT,
        ST_RGAP,
        ST_RREAD,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    // True in the states of the programming phase (elevated supply).
    function automatic logic in_prog_phase(input seq_state_e s);
        return (s == ST_CHECK) || (s == ST_PULSE) || (s == ST_PGAP) ||
               (s == ST_VERIFY) || (s == ST_VGAP) || (s == ST_NEXT);
    endfunction

endpackage

// File: rtl/otp_cyc_timer.sv
// Down-counting cycle timer. A load sets the count; the count then
// decrements to zero and holds. zero_o is high while the count is zero.
// Assumes load_val_i fits in W bits.
module otp_cyc_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Load or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= load_val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/otp_addr_step.sv
// Address walker: clears to 0, steps up by one, flags the top address.
// Assumes the array spans the full 2^AW address range.
module otp_addr_step #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);

    logic [AW-1:0] addr_q;

    // Clear has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (clr_i)  addr_q <= '0;
        else if (step_i) addr_q <= addr_q + 1'b1;
    end

    assign addr_o = addr_q;
    assign last_o = (addr_q == {AW{1'b1}});

endmodule

// File: rtl/otp_try_ctr.sv
// Counts extra pulses applied to the current address. cap_o is high once
// MAX_TRIES pulses have been issued (count == MAX_TRIES-1 after the first).
// Assumes MAX_TRIES >= 1 and that clr_i precedes the first pulse.
module otp_try_ctr #(
    parameter int MAX_TRIES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic cap_o
);

    localparam int CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] cnt_q;

    // Retry count for the address under programming.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cap_o = (cnt_q >= CW'(MAX_TRIES - 1));

endmodule

// File: rtl/otp_prog_seq.sv
// Program-verify sequencer for a byte-wide OTP memory.
// Walks every address, pulses bytes that differ from erased, verifies
// each pulse, retries up to MAX_PULSES, then reads the whole array back
// at nominal supply. Assumes src_data_i is a combinational answer for
// src_addr_o and mem_rdata_i is valid VFY_DLY cycles after CE falls.
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int PULSE_CYC  = 20,
    parameter int MAX_PULSES = 4,
    parameter int VFY_DLY    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              done_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [ADDR_W-1:0] src_addr_o,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_ce_n_o,
    output logic              mem_hv_o,
    output logic              supply_hi_o
);

    localparam int TMR_MAX = (PULSE_CYC > VFY_DLY) ? PULSE_CYC : VFY_DLY;
    localparam int TW      = $clog2(TMR_MAX + 1);
    localparam logic [TW-1:0]     PULSE_LOAD = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0]     VFY_LOAD   = TW'(VFY_DLY - 1);
    localparam logic [DATA_W-1:0] ERASED     = {DATA_W{1'b1}};

    seq_state_e state_q, state_d;

    logic              tmr_load_pulse, tmr_load_vfy, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              addr_clr, addr_step, addr_last;
    logic [ADDR_W-1:0] cur_addr;
    logic              try_clr, try_inc, try_cap;
    logic              byte_match, src_erased, idle_like;
    logic [ADDR_W-1:0] fail_addr_q;

    assign byte_match = (mem_rdata_i == src_data_i);
    assign src_erased = (src_data_i == ERASED);
    assign idle_like  = (state_q == ST_IDLE) || (state_q == ST_DONE) ||
                        (state_q == ST_FAIL);
    assign tmr_val    = tmr_load_pulse ? PULSE_LOAD : VFY_LOAD;

    otp_cyc_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load_pulse | tmr_load_vfy),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    otp_addr_step #(.AW(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (addr_clr),
        .step_i (addr_step),
        .addr_o (cur_addr),
        .last_o (addr_last)
    );

    otp_try_ctr #(.MAX_TRIES(MAX_PULSES)) u_tries (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (try_clr),
        .inc_i (try_inc),
        .cap_o (try_cap)
    );

    // Next-state and control strobes for the sequencer.
    always_comb begin
        state_d        = state_q;
        tmr_load_pulse = 1'b0;
        tmr_load_vfy   = 1'b0;
        addr_clr       = 1'b0;
        addr_step      = 1'b0;
        try_clr        = 1'b0;
        try_inc        = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start_i) begin
                    addr_clr = 1'b1;
                    state_d  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (src_erased) begin
                    state_d = ST_NEXT;
                end else begin
                    try_clr        = 1'b1;
                    tmr_load_pulse = 1'b1;
                    state_d        = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) state_d = ST_PGAP;
            end
            ST_PGAP: begin
                tmr_load_vfy = 1'b1;
                state_d      = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (tmr_zero) begin
                    if (byte_match) begin
                        state_d = ST_NEXT;
                    end else if (try_cap) begin
                        state_d = ST_FAIL;
                    end else begin
                        try_inc = 1'b1;
                        state_d = ST_VGAP;
                    end
                end
            end
            ST_VGAP: begin
                tmr_load_pulse = 1'b1;
                state_d        = ST_PULSE;
            end
            ST_NEXT: begin
                if (addr_last) begin
                    addr_clr = 1'b1;
                    state_d  = ST_RGAP;
                end else begin
                    addr_step = 1'b1;
                    state_d   = ST_CHECK;
                end
            end
            ST_RGAP: begin
                tmr_load_vfy = 1'b1;
                state_d      = ST_RREAD;
            end
            ST_RREAD: begin
                if (tmr_zero) begin
                    if (!byte_match) begin
                        state_d = ST_FAIL;
                    end else if (addr_last) begin
                        state_d = ST_DONE;
                    end else begin
                        addr_step = 1'b1;
                        state_d   = ST_RGAP;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the failing address on entry to the failure state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fail_addr_q <= '0;
        else if (idle_like && start_i)
            fail_addr_q <= '0;
        else if (state_d == ST_FAIL && state_q != ST_FAIL)
            fail_addr_q <= cur_addr;
    end

    assign done_o      = (state_q == ST_DONE);
    assign err_o       = (state_q == ST_FAIL);
    assign fail_addr_o = fail_addr_q;
    assign src_addr_o  = cur_addr;
    assign mem_addr_o  = cur_addr;
    assign mem_hv_o    = (state_q == ST_PULSE);
    assign mem_ce_n_o  = !((state_q == ST_PULSE) || (state_q == ST_VERIFY) ||
                           (state_q == ST_RREAD));
    assign mem_wdata_o = (state_q == ST_PULSE) ? src_data_i : ERASED;
    assign supply_hi_o = in_prog_phase(state_q);

endmodule

// File: rtl/otp_prog_seq_chk.sv
// Checker for otp_prog_seq: pulse shape, enable/high-voltage ordering,
// address stability and end-of-run flags, observed at the ports.
// Assumes it is bound to every otp_prog_seq instance.
module otp_prog_seq_chk #(
    parameter int ADDR_W    = 4,
    parameter int PULSE_CYC = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic              err_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ce_n_o,
    input logic              mem_hv_o,
    input logic              supply_hi_o
);

    localparam int RW = $clog2(PULSE_CYC + 2);

    logic [RW-1:0] hv_run;

    // Length of the current run of high-voltage cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        hv_run <= '0;
        else if (mem_hv_o) hv_run <= hv_run + 1'b1;
        else               hv_run <= '0;
    end

    a_r2_hv_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hv_o |-> !mem_ce_n_o);

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_hv_o) |-> (hv_run == RW'(PULSE_CYC)));

    a_r2_pulse_not_long: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hv_o |-> (hv_run < RW'(PULSE_CYC)));

    a_r3_hv_rise_after_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_hv_o) |-> $past(mem_ce_n_o));

    a_r3_hv_fall_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_hv_o) |-> mem_ce_n_o);

    a_r7_addr_moves_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr_o) |-> mem_ce_n_o);

    a_r8_hv_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
        mem_hv_o |-> supply_hi_o);

    a_r10_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    a_r10_quiet_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |-> (mem_ce_n_o && !mem_hv_o && !supply_hi_o));

endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .ADDR_W    (ADDR_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .err_o       (err_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_hv_o    (mem_hv_o),
    .supply_hi_o (supply_hi_o)
);

// File: tb/otp_prog_seq_tb.sv
// Directed bench: a behavioural OTP memory model with per-address pulse
// needs, early-read corruption and an optional disturb at supply drop.
module otp_prog_seq_tb;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int PW = 20;
    localparam int MP = 4;
    localparam int VD = 3;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, err, ce_n, hv, sup;
    logic [AW-1:0] fail_addr, src_addr, addr;
    logic [DW-1:0] src_data, wdata, rdata;

    always #5 clk = ~clk;

    // Bench-owned source image and model controls.
    logic [DW-1:0] data_arr [N];
    int            need     [N];
    bit            clr_req  = 1'b0;
    bit            drift_en = 1'b0;
    logic [AW-1:0] drift_addr = '0;

    // Model state.
    logic [DW-1:0] mem    [N];
    int            pcount [N];
    int            plen, ce_low, width_err, ff_err, sup_err, order_err, fr_cnt;
    logic [AW-1:0] last_paddr, paddr;
    logic [DW-1:0] pdata;
    logic          prev_ce, prev_sup;

    int checks = 0;
    int failures = 0;

    assign src_data = data_arr[src_addr];
    assign rdata = (!ce_n && !hv && ce_low >= VD - 1) ? mem[addr] : ~mem[addr];

    otp_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PW), .MAX_PULSES(MP), .VFY_DLY(VD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done), .err_o(err),
        .fail_addr_o(fail_addr), .src_addr_o(src_addr), .src_data_i(src_data),
        .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
        .mem_ce_n_o(ce_n), .mem_hv_o(hv), .supply_hi_o(sup)
    );

    // Behavioural OTP memory: programs a byte after need[a] full pulses.
    always @(posedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < N; i++) begin
                mem[i]    <= '1;
                pcount[i] <= 0;
            end
            plen <= 0; ce_low <= 0; width_err <= 0; ff_err <= 0;
            sup_err <= 0; order_err <= 0; fr_cnt <= 0; last_paddr <= '0;
            pdata <= '1; paddr <= '0; prev_ce <= 1'b1; prev_sup <= 1'b0;
        end else begin
            if (!ce_n && hv) begin
                plen  <= plen + 1;
                pdata <= wdata;
                paddr <= addr;
                if (!sup) sup_err <= sup_err + 1;
            end else if (plen > 0) begin
                plen <= 0;
                if (plen != PW) width_err <= width_err + 1;
                if (data_arr[paddr] == 8'hFF) ff_err <= ff_err + 1;
                if (paddr < last_paddr) order_err <= order_err + 1;
                last_paddr     <= paddr;
                pcount[paddr]  <= pcount[paddr] + 1;
                if (pcount[paddr] + 1 >= need[paddr])
                    mem[paddr] <= mem[paddr] & pdata;
            end
            if (!ce_n && prev_ce && !sup) begin
                if (int'(addr) != fr_cnt) order_err <= order_err + 1;
                fr_cnt <= fr_cnt + 1;
            end
            if (prev_sup && !sup && drift_en) mem[drift_addr] <= '1;
            ce_low   <= ce_n ? 0 : ce_low + 1;
            prev_ce  <= ce_n;
            prev_sup <= sup;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_image(input int need_mode);
        for (int a = 0; a < N; a++) begin
            data_arr[a] = (a % 4 == 3) ? 8'hFF : (8'h5A ^ 8'(a * 8'h13));
            need[a]     = (need_mode == 1) ? (a % 3) + 1 : 1;
        end
        drift_en = 1'b0;
        @(negedge clk) clr_req = 1'b1;
        @(negedge clk) clr_req = 1'b0;
    endtask

    task automatic run(input bit poke_busy);
        int cnt;
        cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!(done || err) && cnt < 20000) begin
            @(negedge clk);
            cnt++;
            if (poke_busy && cnt == 50) start = 1'b1;
            if (poke_busy && cnt == 51) start = 1'b0;
        end
        chk(cnt < 20000, "R10 run finishes", cnt, 20000);
        repeat (3) @(negedge clk);
        chk(ce_n && !hv, "R10 ce high hv low after run", {ce_n, hv}, 2);
    endtask

    function automatic int pulse_mismatches();
        int m = 0;
        for (int a = 0; a < N; a++)
            if (pcount[a] != ((data_arr[a] == 8'hFF) ? 0 : need[a])) m++;
        return m;
    endfunction

    function automatic int mem_mismatches();
        int m = 0;
        for (int a = 0; a < N; a++)
            if (mem[a] != data_arr[a]) m++;
        return m;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(ce_n == 1'b1, "R1 ce_n in reset", ce_n, 1);
        chk(hv == 1'b0 && sup == 1'b0, "R1 hv/supply in reset", {hv, sup}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !err, "R1 flags after reset", {done, err}, 0);
        chk(ce_n && !hv && !sup, "R1 memory side idle", {ce_n, hv, sup}, 4);
    endtask

    task automatic t_basic();
        load_image(0);
        run(1'b0);
        chk(done && !err, "R10 clean run done", {done, err}, 2);
        chk(pulse_mismatches() == 0, "R2 one pulse per byte", pulse_mismatches(), 0);
        chk(mem_mismatches() == 0, "R2 programmed data", mem_mismatches(), 0);
        chk(width_err == 0, "R2 pulse width", width_err, 0);
        chk(ff_err == 0 && pcount[3] == 0, "R6 erased bytes skipped", ff_err, 0);
        chk(order_err == 0, "R7 ascending order", order_err, 0);
        chk(sup_err == 0 && !sup, "R8 supply select", sup_err, 0);
        chk(fr_cnt == N, "R9 final pass reads all", fr_cnt, N);
    endtask

    task automatic t_retry();
        load_image(1);
        run(1'b0);
        chk(done && !err, "R4 retry run done", {done, err}, 2);
        chk(pulse_mismatches() == 0, "R4 pulses equal need", pulse_mismatches(), 0);
        chk(pcount[2] == 3, "R4 three pulses at addr 2", pcount[2], 3);
        chk(width_err == 0, "R3 verify only after full pulses", width_err, 0);
        chk(mem_mismatches() == 0, "R3 verify sampled late enough", mem_mismatches(), 0);
    endtask

    task automatic t_cap();
        load_image(0);
        need[5] = MP + 5;
        run(1'b0);
        chk(err && !done, "R5 error on cap", {done, err}, 1);
        chk(fail_addr == 4'd5, "R5 fail address", fail_addr, 5);
        chk(pcount[5] == MP, "R5 pulses at capped addr", pcount[5], MP);
        chk(pcount[6] == 0, "R5 no later pulses", pcount[6], 0);
        chk(fr_cnt == 0, "R5 no final pass", fr_cnt, 0);
    endtask

    task automatic t_final_fail();
        load_image(0);
        drift_addr = 4'd9;
        drift_en   = 1'b1;
        run(1'b0);
        chk(err && !done, "R9 final mismatch error", {done, err}, 1);
        chk(fail_addr == 4'd9, "R9 fail address", fail_addr, 9);
        chk(fr_cnt == 10, "R9 final reads up to failure", fr_cnt, 10);
        chk(order_err == 0, "R7 final pass order", order_err, 0);
    endtask

    task automatic t_busy_start();
        load_image(0);
        run(1'b1);
        chk(done && !err, "R10 busy start ignored", {done, err}, 2);
        chk(pulse_mismatches() == 0, "R10 no extra pulses", pulse_mismatches(), 0);
        chk(fr_cnt == N, "R10 single final pass", fr_cnt, N);
    endtask

    initial begin
        for (int a = 0; a < N; a++) begin
            data_arr[a] = '1;
            need[a]     = 1;
        end
        clr_req = 1'b1;
        t_reset();
        clr_req = 1'b0;
        t_basic();
        t_retry();
        t_cap();
        t_final_fail();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule